// File: doc/BRIEF.md
# Per-CPU Cross-Call Queue Interrupt Controller

This block keeps the two pointer registers of one processor's cross-call interrupt queue, a head pointer that software advances as it consumes entries and a tail pointer that the producer side moves as it appends them. While the two pointers hold different values the queue holds work and the block asks the core for an interrupt trap. The trap type is 0x7c. The queue memory itself, trap vectoring and handler code lie outside the block.

Software reaches both pointers through a small register port. Each access carries a pointer select, a write enable, 64-bit write data and the privilege level of the requester. Supervisor code may read both pointers and move the head, but only hypervisor code may move the tail. An access that breaks these rules gets a single-cycle access-fault trap request of type 0x14 and changes nothing.

The interrupt request is a level. It is formed every cycle from the registered pointers, the current privilege level and the interrupt-enable bit of the processor state. It is withheld in hypervisor mode and reappears as soon as the core drops back with the queue still non-empty. A handler clears it by reading the tail and writing that value into the head.

Top module: `cpu_intq_ctrl`

## Requirements
- R1: After reset both pointers are zero, rd_data is zero, and fault_req, intr_req, fault_tt and intr_tt are all low.
- R2: A head write (acc_sel=0, acc_we=1) at privilege supervisor (acc_priv=1) or hypervisor (acc_priv=2) loads acc_wdata into the head in the next clock edge, with no fault.
- R3: A tail write (acc_sel=1, acc_we=1) at any privilege other than hypervisor is refused: the tail keeps its value and fault_req is high with fault_tt=0x14 in the cycle after the access.
- R4: A tail write at hypervisor privilege loads acc_wdata into the tail in the next clock edge and raises no fault.
- R5: intr_req is high with intr_tt=0x7c whenever head differs from tail, intr_en is 1, privilege is user (0) or supervisor (1), and no fault is being signalled; intr_tt is zero when intr_req is low.
- R6: intr_req stays low at hypervisor privilege and at the reserved code 3 even while head differs from tail, and rises in the same cycle that privilege returns to supervisor.
- R7: intr_req stays low while intr_en is 0.
- R8: Reading the tail and writing the returned value into the head drops intr_req in the cycle after that head write.
- R9: Any access at user privilege (acc_priv=0), or at the reserved code 3, faults with fault_tt=0x14 and leaves both pointers and rd_data unchanged.
- R10: fault_req lasts exactly one cycle per faulting access, and intr_req is low in every cycle in which fault_req is high.
- R11: A read (acc_we=0) at supervisor or hypervisor privilege returns the selected pointer on rd_data in the cycle after the access; rd_data holds its value until the next permitted read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Register access strobe, one access per cycle |
| acc_sel | input | 1 | Pointer select: 0 head, 1 tail |
| acc_we | input | 1 | 1 write, 0 read |
| acc_wdata | input | PTR_W (64) | Write data |
| acc_priv | input | 2 | Requester privilege: 0 user, 1 supervisor, 2 hypervisor, 3 reserved |
| intr_en | input | 1 | Interrupt-enable bit of the processor state |
| rd_data | output | PTR_W (64) | Registered read data |
| fault_req | output | 1 | Access-fault trap request pulse |
| fault_tt | output | 8 | Trap type of the fault (0x14 when fault_req, else 0) |
| intr_req | output | 1 | Queue interrupt trap request (level) |
| intr_tt | output | 8 | Trap type of the interrupt (0x7c when intr_req, else 0) |

## Verification
A wrong pointer value shows at the ports in two ways. It appears on rd_data one cycle after the next permitted read of that pointer. It also shows as a wrong intr_req level in the very cycle the pointers stop matching or start matching. A wrongly granted tail write therefore shows up on the first read-back. A missing or doubled fault pulse shows in the cycle right after the offending access. A gating error on privilege or enable shows with no delay, because the request is formed combinationally from those inputs.

// File: rtl/intq_pkg.sv
package intq_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_HYPER = 2'd2,
        PRIV_RSVD  = 2'd3
    } priv_e;

    typedef enum logic {
        SEL_HEAD = 1'b0,
        SEL_TAIL = 1'b1
    } qsel_e;

    localparam int unsigned TT_W = 8;
    localparam logic [TT_W-1:0] TT_BAD_ACCESS = 8'h14;
    localparam logic [TT_W-1:0] TT_QUEUE_INT  = 8'h7c;

    localparam int unsigned NUM_PTR = 2;

    // decoded outcome of one register access
    typedef struct packed {
        logic rd_ok;
        logic head_wr;
        logic tail_wr;
        logic fault;
    } acc_dec_t;

    function automatic logic priv_may_access(priv_e p);
        return (p == PRIV_SUPER) || (p == PRIV_HYPER);
    endfunction

    function automatic logic priv_may_move_tail(priv_e p);
        return p == PRIV_HYPER;
    endfunction

    function automatic logic priv_may_take_intr(priv_e p);
        return (p == PRIV_USER) || (p == PRIV_SUPER);
    endfunction

endpackage

// File: rtl/intq_access_dec.sv
module intq_access_dec
    import intq_pkg::*;
(
    input  logic     valid,
    input  qsel_e    sel,
    input  logic     we,
    input  priv_e    priv,
    output acc_dec_t dec
);
    logic allowed;
    logic tail_block;

    always_comb begin
        tail_block  = we && (sel == SEL_TAIL) && !priv_may_move_tail(priv);
        allowed     = priv_may_access(priv) && !tail_block;
        dec.rd_ok   = valid && allowed && !we;
        dec.head_wr = valid && allowed && we && (sel == SEL_HEAD);
        dec.tail_wr = valid && allowed && we && (sel == SEL_TAIL);
        dec.fault   = valid && !allowed;
    end
endmodule

// File: rtl/intq_ptr_regs.sv
module intq_ptr_regs
    import intq_pkg::*;
#(
    parameter int unsigned PTR_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  acc_dec_t         dec,
    input  qsel_e            sel,
    input  logic [PTR_W-1:0] wdata,
    output logic [PTR_W-1:0] head_q,
    output logic [PTR_W-1:0] tail_q,
    output logic [PTR_W-1:0] rd_q
);
    logic [NUM_PTR-1:0][PTR_W-1:0] ptr_q;
    logic [NUM_PTR-1:0]            ptr_we;

    assign ptr_we[SEL_HEAD] = dec.head_wr;
    assign ptr_we[SEL_TAIL] = dec.tail_wr;

    for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
        always_ff @(posedge clk) begin
            if (rst)
                ptr_q[i] <= '0;
            else if (ptr_we[i])
                ptr_q[i] <= wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_q <= '0;
        else if (dec.rd_ok)
            rd_q <= ptr_q[sel];
    end

    assign head_q = ptr_q[SEL_HEAD];
    assign tail_q = ptr_q[SEL_TAIL];
endmodule

// File: rtl/intq_trap_gen.sv
module intq_trap_gen
    import intq_pkg::*;
#(
    parameter int unsigned PTR_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fault_now,
    input  logic [PTR_W-1:0] head_q,
    input  logic [PTR_W-1:0] tail_q,
    input  priv_e            priv,
    input  logic             ie,
    output logic             fault_req,
    output logic [TT_W-1:0]  fault_tt,
    output logic             intr_req,
    output logic [TT_W-1:0]  intr_tt
);
    logic fault_q;
    logic pending;

    always_ff @(posedge clk) begin
        if (rst)
            fault_q <= 1'b0;
        else
            fault_q <= fault_now;
    end

    always_comb begin
        pending   = head_q != tail_q;
        intr_req  = pending && ie && priv_may_take_intr(priv) && !fault_q;
        intr_tt   = intr_req ? TT_QUEUE_INT : '0;
        fault_req = fault_q;
        fault_tt  = fault_q ? TT_BAD_ACCESS : '0;
    end
endmodule

// File: rtl/cpu_intq_ctrl.sv
module cpu_intq_ctrl
    import intq_pkg::*;
#(
    parameter int unsigned PTR_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             acc_valid,
    input  logic             acc_sel,
    input  logic             acc_we,
    input  logic [PTR_W-1:0] acc_wdata,
    input  logic [1:0]       acc_priv,
    input  logic             intr_en,
    output logic [PTR_W-1:0] rd_data,
    output logic             fault_req,
    output logic [7:0]       fault_tt,
    output logic             intr_req,
    output logic [7:0]       intr_tt
);
    priv_e            priv_cur;
    qsel_e            sel_cur;
    acc_dec_t         dec;
    logic [PTR_W-1:0] head_q;
    logic [PTR_W-1:0] tail_q;

    assign priv_cur = priv_e'(acc_priv);
    assign sel_cur  = qsel_e'(acc_sel);

    intq_access_dec u_dec (
        .valid (acc_valid),
        .sel   (sel_cur),
        .we    (acc_we),
        .priv  (priv_cur),
        .dec   (dec)
    );

    intq_ptr_regs #(.PTR_W(PTR_W)) u_ptr (
        .clk    (clk),
        .rst    (rst),
        .dec    (dec),
        .sel    (sel_cur),
        .wdata  (acc_wdata),
        .head_q (head_q),
        .tail_q (tail_q),
        .rd_q   (rd_data)
    );

    intq_trap_gen #(.PTR_W(PTR_W)) u_trap (
        .clk       (clk),
        .rst       (rst),
        .fault_now (dec.fault),
        .head_q    (head_q),
        .tail_q    (tail_q),
        .priv      (priv_cur),
        .ie        (intr_en),
        .fault_req (fault_req),
        .fault_tt  (fault_tt),
        .intr_req  (intr_req),
        .intr_tt   (intr_tt)
    );
endmodule

// File: rtl/intq_ctrl_checker.sv
module intq_ctrl_checker #(
    parameter int unsigned PTR_W = 64
) (
    input logic             clk,
    input logic             rst,
    input logic             acc_valid,
    input logic             acc_sel,
    input logic             acc_we,
    input logic [PTR_W-1:0] acc_wdata,
    input logic [1:0]       acc_priv,
    input logic             intr_en,
    input logic             fault_req,
    input logic             intr_req,
    input logic [PTR_W-1:0] head_q,
    input logic [PTR_W-1:0] tail_q
);
    AST_HEAD_WRITE: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_we && !acc_sel && (acc_priv == 2'd1 || acc_priv == 2'd2))
        |=> (head_q == $past(acc_wdata) && !fault_req)); // R2

    AST_TAIL_GUARD: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_we && acc_sel && acc_priv != 2'd2)
        |=> ($stable(tail_q) && fault_req)); // R3

    AST_TAIL_HYPER: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_we && acc_sel && acc_priv == 2'd2)
        |=> (tail_q == $past(acc_wdata) && !fault_req)); // R4

    AST_INTR_GATE: assert property (@(posedge clk) disable iff (rst)
        intr_req |-> (intr_en && (acc_priv == 2'd0 || acc_priv == 2'd1) && head_q != tail_q)); // R6

    AST_USER_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && (acc_priv == 2'd0 || acc_priv == 2'd3))
        |=> ($stable(head_q) && $stable(tail_q) && fault_req)); // R9

    AST_FAULT_CAUSE: assert property (@(posedge clk) disable iff (rst)
        fault_req |-> $past(acc_valid)); // R10
endmodule

bind cpu_intq_ctrl intq_ctrl_checker #(.PTR_W(PTR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .acc_valid (acc_valid),
    .acc_sel   (acc_sel),
    .acc_we    (acc_we),
    .acc_wdata (acc_wdata),
    .acc_priv  (acc_priv),
    .intr_en   (intr_en),
    .fault_req (fault_req),
    .intr_req  (intr_req),
    .head_q    (head_q),
    .tail_q    (tail_q)
);

// File: tb/cpu_intq_ctrl_bench.sv
`timescale 1ns/1ps
module cpu_intq_ctrl_bench;
    localparam int unsigned PTR_W = 64;
    localparam time CYC = 20ns;

    logic             clk = 1'b0;
    logic             rst;
    logic             acc_valid;
    logic             acc_sel;
    logic             acc_we;
    logic [PTR_W-1:0] acc_wdata;
    logic [1:0]       acc_priv;
    logic             intr_en;
    logic [PTR_W-1:0] rd_data;
    logic             fault_req;
    logic [7:0]       fault_tt;
    logic             intr_req;
    logic [7:0]       intr_tt;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [PTR_W-1:0] m_head, m_tail, m_rd;

    always #(CYC/2) clk = ~clk;

    cpu_intq_ctrl #(.PTR_W(PTR_W)) u_cpu_intq_ctrl (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_sel(acc_sel),
        .acc_we(acc_we), .acc_wdata(acc_wdata), .acc_priv(acc_priv),
        .intr_en(intr_en), .rd_data(rd_data), .fault_req(fault_req),
        .fault_tt(fault_tt), .intr_req(intr_req), .intr_tt(intr_tt)
    );

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one access; returns with outputs of the cycle after it settled
    task automatic acc(input logic s, input logic w, input logic [63:0] d, input logic [1:0] p);
        @(negedge clk);
        acc_valid = 1'b1; acc_sel = s; acc_we = w; acc_wdata = d; acc_priv = p;
        @(negedge clk);
        acc_valid = 1'b0;
        #1;
    endtask

    task automatic idle(input logic [1:0] p, input logic ie);
        @(negedge clk);
        acc_priv = p; intr_en = ie;
        #1;
    endtask

    initial begin
        #(CYC * 150000);
        n_bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic legal, exp_fault;
        rst = 1'b1; acc_valid = 1'b0; acc_sel = 1'b0; acc_we = 1'b0;
        acc_wdata = '0; acc_priv = 2'd1; intr_en = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(rd_data, 0, "R1 rd_data");
        chk(fault_req, 0, "R1 fault_req");
        chk(fault_tt, 0, "R1 fault_tt");
        chk(intr_req, 0, "R1 intr_req");
        chk(intr_tt, 0, "R1 intr_tt");
        m_head = '0; m_tail = '0; m_rd = '0;

        // sweep privilege x select x direction
        for (int p = 0; p < 4; p++) begin
            for (int s = 0; s < 2; s++) begin
                for (int w = 0; w < 2; w++) begin
                    logic [63:0] d;
                    d = 64'h0123_4567_0000_0000 + 64'(p * 16 + s * 4 + w + 1);
                    legal = (p == 1 || p == 2) && !(w == 1 && s == 1 && p != 2);
                    exp_fault = !legal;
                    if (legal && w == 1) begin
                        if (s == 0) m_head = d; else m_tail = d;
                    end
                    if (legal && w == 0) m_rd = (s == 0) ? m_head : m_tail;
                    acc(s[0], w[0], d, p[1:0]);
                    if (p == 0 || p == 3) begin
                        chk(fault_req, 1, "R9 user fault");
                        chk(fault_tt, 8'h14, "R9 user fault_tt");
                    end else if (s == 1 && w == 1 && p == 1) begin
                        chk(fault_req, 1, "R3 tail write fault");
                        chk(fault_tt, 8'h14, "R3 fault_tt");
                    end else if (w == 1) begin
                        chk(fault_req, 0, s == 1 ? "R4 no fault" : "R2 no fault");
                    end else begin
                        chk(fault_req, exp_fault, "R11 read no fault");
                    end
                    chk(rd_data, m_rd, "R11 rd_data after access");
                    idle(2'd2, 1'b1);
                    chk(fault_req, 0, "R10 single cycle fault");
                    acc(1'b0, 1'b0, 64'd0, 2'd2);
                    chk(rd_data, m_head, "R2 head readback");
                    acc(1'b1, 1'b0, 64'd0, 2'd1);
                    chk(rd_data, m_tail, "R4 tail readback");
                    m_rd = m_tail;
                end
            end
        end

        // delivery gating sweep
        for (int pend = 0; pend < 2; pend++) begin
            acc(1'b1, 1'b1, 64'h50 + 64'(pend), 2'd2);
            acc(1'b0, 1'b1, 64'h50, 2'd2);
            for (int p = 0; p < 4; p++) begin
                for (int ie = 0; ie < 2; ie++) begin
                    logic e;
                    idle(p[1:0], ie[0]);
                    e = (pend == 1) && (ie == 1) && (p == 0 || p == 1);
                    chk(intr_req, e, ie == 0 ? "R7 enable gate" : (p >= 2 ? "R6 hyper hold" : "R5 deliver"));
                    chk(intr_tt, e ? 64'h7c : 64'h0, "R5 intr_tt");
                end
            end
        end

        // hold in hypervisor, deliver on return
        acc(1'b1, 1'b1, 64'hABCD, 2'd2);
        idle(2'd2, 1'b1);
        chk(intr_req, 0, "R6 held cycle 1");
        idle(2'd2, 1'b1);
        chk(intr_req, 0, "R6 held cycle 2");
        @(negedge clk); acc_priv = 2'd1; #1;
        chk(intr_req, 1, "R6 delivered on return");

        // fault suppresses interrupt for one cycle
        acc(1'b1, 1'b1, 64'h9999, 2'd1);
        chk(fault_req, 1, "R10 fault pulse");
        chk(intr_req, 0, "R10 intr masked with fault");
        idle(2'd1, 1'b1);
        chk(fault_req, 0, "R10 fault width");
        chk(intr_req, 1, "R10 intr back");

        // back-to-back faults give consecutive pulses
        @(negedge clk);
        acc_valid = 1'b1; acc_sel = 1'b0; acc_we = 1'b0; acc_priv = 2'd0;
        @(negedge clk); #1;
        chk(fault_req, 1, "R10 b2b pulse 1");
        @(negedge clk); acc_valid = 1'b0; #1;
        chk(fault_req, 1, "R10 b2b pulse 2");
        idle(2'd1, 1'b1);
        chk(fault_req, 0, "R10 b2b end");

        // clear sequence
        acc(1'b1, 1'b0, 64'd0, 2'd1);
        chk(rd_data, 64'hABCD, "R8 tail read");
        chk(intr_req, 1, "R8 pending before clear");
        acc(1'b0, 1'b1, rd_data, 2'd1);
        chk(intr_req, 0, "R8 cleared");
        idle(2'd1, 1'b1);
        chk(intr_req, 0, "R8 stays clear");

        // user read leaves rd_data untouched
        acc(1'b0, 1'b0, 64'd0, 2'd0);
        chk(rd_data, 64'hABCD, "R9 rd_data held");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule